// File: doc/BRIEF.md
# Two-Wire Command-Protocol Slave

This block is the serial front end of a register-configured device. It watches an oversampled two-wire bus (clock and data lines, both open drain), finds START and STOP conditions, and answers a control byte whose upper nibble is a fixed device code and whose next three bits must match a select value held elsewhere in the chip. A write continues with a command byte. The command names a register and sets the register pointer. Then, depending on the register, zero, one or two data bytes follow. A read returns the register named by the last accepted command, high byte first when the register is two bytes wide.

The surrounding register file does two things. It reports the byte length of the command currently on `cmd_o`, combinationally. It supplies that register's read value. Every accepted write byte, and every standalone command, leaves the block as a single beat on a valid/ready stream. Back-pressure rules for that stream: `wr_valid_o` rises after the eighth bit of a byte has been sampled. The payload holds still while valid is high and ready is low. Valid stays up until ready is seen or the bus clock falls into the acknowledge slot, whichever comes first. The byte is acknowledged on the bus only if the beat was taken; otherwise the master sees NACK. While `busy_i` is high (a nonvolatile write in progress) the block refuses everything with NACK and emits no beats.

Top module: `tws_cmd_slave`

## Requirements
- R1: A control byte is acknowledged only when bits 7:4 equal 4'b1011 and bits 3:1 equal `dev_sel_i`. Bit 0 selects the direction (0 write, 1 read). On a mismatch the block answers NACK and leaves SDA released until the next START.
- R2: On a write, the byte after the control byte is the command byte. It is acknowledged and becomes the value on `cmd_o` from the acknowledge onward.
- R3: Data bytes after the command are accepted up to the length `cmd_len_i` reports (0, 1 or 2). Each accepted byte produces exactly one write beat with `wr_pos_o` 0 for the first (high) byte and 1 for the second. Bytes beyond the length are answered with NACK and produce no beat.
- R4: A command whose length is 0 is standalone. Its command byte produces one beat with `wr_nodata_o` = 1 and `wr_cmd_o` equal to the command.
- R5: A byte whose beat is not taken before the acknowledge slot begins is answered with NACK. The beat payload is stable while valid waits for ready.
- R6: While `busy_i` is 1, every control, command and data byte is answered with NACK and no write beat is issued. Normal answers resume once it returns to 0.
- R7: A read sends `rd_data_i[15:8]` then `rd_data_i[7:0]` for a two-byte register, and `rd_data_i[7:0]` for a one-byte register. SDA is only pulled low while the synchronized bus clock is low.
- R8: A master NACK after a read byte ends the read. SDA stays released until the next START.
- R9: A START or STOP in the middle of a byte abandons the transfer. A START restarts control-byte matching and releases SDA.
- R10: SDA is released and no write beat is pending while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_pull_o | output | 1 | 1 drives the data line low, 0 releases it |
| dev_sel_i | input | 3 | Programmed device select value |
| busy_i | input | 1 | Nonvolatile write in progress; refuse all transfers |
| cmd_o | output | 8 | Command being decoded or the current register pointer |
| cmd_len_i | input | 2 | Byte length of the register named on `cmd_o` |
| rd_data_i | input | 16 | Read value of the register named on `cmd_o` |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_cmd_o | output | 8 | Command of the beat |
| wr_data_o | output | 8 | Data byte of the beat |
| wr_pos_o | output | 1 | 0 first/high byte, 1 second/low byte |
| wr_nodata_o | output | 1 | Beat is a standalone command without data |

## Verification
The bench builds the block with its default device code 4'b1011 and a two-stage synchronizer, and ties the select input to 3'b101. It runs the bus with ten system clocks per quarter bus period. That margin puts the acknowledge slot far enough from the eighth-bit edge that both the taken-beat and the refused-beat cases can be driven deliberately. Its register model defines one standalone command, one-byte registers and two-byte registers. This lets a single build cover the zero, one, two and overflow data-byte paths and both read widths.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_BYTES = 2;
  localparam int LEN_W     = 2;
  localparam int SEL_W     = 3;
  localparam int CODE_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_DECIDE,
    ST_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_WAIT
  } tws_state_e;

  typedef enum logic [1:0] {
    PH_CTRL,
    PH_CMD,
    PH_DATA
  } tws_phase_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '1;
    else        stg <= {stg[STAGES-2:0], din};
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/tws_bus_cond.sv
module tws_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_prev;
  assign scl_fall = ~scl_s & scl_prev;
  assign start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1011
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_rise,
  input  logic                        scl_fall,
  input  logic                        start_p,
  input  logic                        stop_p,
  input  logic                        sda_s,
  input  logic [SEL_W-1:0]            dev_sel_i,
  input  logic                        busy_i,
  input  logic [LEN_W-1:0]            cmd_len_i,
  input  logic [REG_BYTES*BYTE_W-1:0] rd_data_i,
  input  logic                        wr_ready_i,
  output logic                        sda_pull_o,
  output logic [BYTE_W-1:0]           cmd_o,
  output logic                        wr_valid_o,
  output logic [BYTE_W-1:0]           wr_cmd_o,
  output logic [BYTE_W-1:0]           wr_data_o,
  output logic                        wr_pos_o,
  output logic                        wr_nodata_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  tws_state_e          state;
  tws_phase_e          phase;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   tx_sh;
  logic [BYTE_W-1:0]   cmd_q;
  logic [LEN_W-1:0]    data_cnt;
  logic                hs_done;
  logic                rd_mode;
  logic                rd_idx;
  logic                pull_q;

  logic                deciding, ctrl_hit, want_wr, hs_now, plain_ok, ack_ok;
  logic [BYTE_W-1:0]   rd_byte;

  assign deciding = (state == ST_DECIDE);
  assign cmd_o    = (deciding && phase == PH_CMD) ? shreg : cmd_q;
  assign ctrl_hit = (shreg[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                    (shreg[SEL_W:1] == dev_sel_i);

  always_comb begin
    want_wr = 1'b0;
    if (deciding) begin
      if (phase == PH_CMD)       want_wr = (cmd_len_i == '0);
      else if (phase == PH_DATA) want_wr = (data_cnt < cmd_len_i);
    end
  end

  always_comb begin
    case (phase)
      PH_CTRL: plain_ok = ctrl_hit;
      PH_CMD:  plain_ok = 1'b1;
      default: plain_ok = 1'b0;
    endcase
  end

  assign wr_valid_o  = want_wr && !hs_done && !busy_i;
  assign hs_now      = hs_done || (wr_valid_o && wr_ready_i);
  assign ack_ok      = want_wr ? hs_now : (plain_ok && !busy_i);
  assign wr_cmd_o    = cmd_o;
  assign wr_data_o   = shreg;
  assign wr_pos_o    = data_cnt[0];
  assign wr_nodata_o = (phase == PH_CMD);

  assign rd_byte = (cmd_len_i == LEN_W'(REG_BYTES) && !rd_idx) ?
                   rd_data_i[REG_BYTES*BYTE_W-1 -: BYTE_W] : rd_data_i[BYTE_W-1:0];

  assign sda_pull_o = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_CTRL;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      cmd_q    <= '0;
      data_cnt <= '0;
      hs_done  <= 1'b0;
      rd_mode  <= 1'b0;
      rd_idx   <= 1'b0;
      pull_q   <= 1'b0;
    end else if (start_p) begin
      state   <= ST_RX;
      phase   <= PH_CTRL;
      bit_cnt <= '0;
      rd_mode <= 1'b0;
      hs_done <= 1'b0;
      pull_q  <= 1'b0;
    end else if (stop_p) begin
      state  <= ST_IDLE;
      pull_q <= 1'b0;
    end else begin
      case (state)
        ST_RX: if (scl_rise) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            state   <= ST_DECIDE;
            hs_done <= 1'b0;
          end
        end
        ST_DECIDE: begin
          if (wr_valid_o && wr_ready_i) hs_done <= 1'b1;
          if (scl_fall) begin
            if (ack_ok) begin
              pull_q <= 1'b1;
              state  <= ST_ACK;
              case (phase)
                PH_CTRL: begin
                  rd_mode <= shreg[0];
                  phase   <= PH_CMD;
                  rd_idx  <= 1'b0;
                end
                PH_CMD: begin
                  cmd_q    <= shreg;
                  phase    <= PH_DATA;
                  data_cnt <= '0;
                end
                default: data_cnt <= data_cnt + 1'b1;
              endcase
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ACK, ST_TX_NEXT: if (scl_fall) begin
          bit_cnt <= '0;
          if (state == ST_TX_NEXT || rd_mode) begin
            tx_sh  <= rd_byte;
            pull_q <= ~rd_byte[BYTE_W-1];
            rd_idx <= (cmd_len_i == LEN_W'(REG_BYTES)) ? ~rd_idx : 1'b0;
            state  <= ST_TX;
          end else begin
            pull_q <= 1'b0;
            state  <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == LAST_BIT) begin
            pull_q <= 1'b0;
            state  <= ST_TX_ACK;
          end else begin
            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
            pull_q  <= ~tx_sh[BYTE_W-2];
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_TX_ACK: if (scl_rise) state <= sda_s ? ST_WAIT : ST_TX_NEXT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tws_cmd_slave.sv
module tws_cmd_slave
  import tws_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE    = 4'b1011,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_pull_o,
  input  logic [SEL_W-1:0]            dev_sel_i,
  input  logic                        busy_i,
  output logic [BYTE_W-1:0]           cmd_o,
  input  logic [LEN_W-1:0]            cmd_len_i,
  input  logic [REG_BYTES*BYTE_W-1:0] rd_data_i,
  output logic                        wr_valid_o,
  input  logic                        wr_ready_i,
  output logic [BYTE_W-1:0]           wr_cmd_o,
  output logic [BYTE_W-1:0]           wr_data_o,
  output logic                        wr_pos_o,
  output logic                        wr_nodata_o
);
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_p, stop_p;

  tws_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  tws_bus_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_p (start_p),
    .stop_p  (stop_p)
  );

  tws_engine #(.DEV_CODE(DEV_CODE)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_p    (start_p),
    .stop_p     (stop_p),
    .sda_s      (sda_s),
    .dev_sel_i  (dev_sel_i),
    .busy_i     (busy_i),
    .cmd_len_i  (cmd_len_i),
    .rd_data_i  (rd_data_i),
    .wr_ready_i (wr_ready_i),
    .sda_pull_o (sda_pull_o),
    .cmd_o      (cmd_o),
    .wr_valid_o (wr_valid_o),
    .wr_cmd_o   (wr_cmd_o),
    .wr_data_o  (wr_data_o),
    .wr_pos_o   (wr_pos_o),
    .wr_nodata_o(wr_nodata_o)
  );
endmodule

// File: rtl/tws_cmd_slave_chk.sv
module tws_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_p,
  input logic       sda_pull_o,
  input logic       wr_valid_o,
  input logic       wr_ready_i,
  input logic [7:0] wr_cmd_o,
  input logic [7:0] wr_data_o,
  input logic       wr_pos_o
);
  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s); // R7

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !sda_pull_o); // R9

  AST_ONE_BEAT_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i) |=> !wr_valid_o); // R3

  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_valid_o && !wr_ready_i) && wr_valid_o) |->
      ($stable(wr_data_o) && $stable(wr_cmd_o) && $stable(wr_pos_o))); // R5

  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rst_n |-> (!sda_pull_o && !wr_valid_o)); // R10
endmodule

bind tws_cmd_slave tws_cmd_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_p   (start_p),
  .sda_pull_o(sda_pull_o),
  .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i),
  .wr_cmd_o  (wr_cmd_o),
  .wr_data_o (wr_data_o),
  .wr_pos_o  (wr_pos_o)
);

// File: tb/tws_cmd_slave_bench.sv
`timescale 1ns/1ps
module tws_cmd_slave_bench;
  localparam int Q = 10;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW = {4'b1011, SEL, 1'b0};
  localparam logic [7:0] CR = {4'b1011, SEL, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0, wr_ready = 1'b1;
  logic sda_pull, wr_valid, wr_pos, wr_nodata;
  logic [7:0] cmd, wr_cmd, wr_data;
  logic [1:0] cmd_len;
  logic [15:0] rd_data;
  logic sda_bus;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] cap_cmd [8];
  logic [7:0] cap_dat [8];
  logic       cap_pos [8];
  logic       cap_nod [8];
  int cap_n = 0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;
  assign cmd_len = (cmd == 8'hD0) ? 2'd0 : (cmd[0] ? 2'd2 : 2'd1);
  assign rd_data = {cmd ^ 8'hF0, cmd ^ 8'h0F};

  tws_cmd_slave u_tws_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .dev_sel_i(SEL), .busy_i(busy),
    .cmd_o(cmd), .cmd_len_i(cmd_len), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_cmd_o(wr_cmd),
    .wr_data_o(wr_data), .wr_pos_o(wr_pos), .wr_nodata_o(wr_nodata)
  );

  always @(negedge clk) begin
    if (wr_valid && wr_ready && cap_n < 8) begin
      cap_cmd[cap_n] = wr_cmd;
      cap_dat[cap_n] = wr_data;
      cap_pos[cap_n] = wr_pos;
      cap_nod[cap_n] = wr_nodata;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic m_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    m_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1;
      tick(Q); b[i] = sda_bus;
      tick(Q); scl_m = 1'b0;
      tick(Q);
    end
    sda_m = !give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(1);
    sda_m = 1'b1; tick(Q - 1);
  endtask

  task automatic t_reset;
    chk(!sda_pull, "R10 pull in reset", sda_pull, 0);
    chk(!wr_valid, "R10 valid in reset", wr_valid, 0);
  endtask

  task automatic t_one_byte_write;
    bit a; int n0 = cap_n;
    m_start;
    m_wbyte(CW, a);    chk(a, "R1 ctrl ack", a, 1);
    m_wbyte(8'h02, a); chk(a, "R2 cmd ack", a, 1);
    chk(cmd == 8'h02, "R2 pointer", cmd, 8'h02);
    m_wbyte(8'h3C, a); chk(a, "R3 data ack", a, 1);
    m_wbyte(8'h11, a); chk(!a, "R3 extra byte nack", a, 0);
    m_stop;
    chk(cap_n == n0 + 1, "R3 beat count", cap_n - n0, 1);
    chk(cap_dat[n0] == 8'h3C && cap_pos[n0] == 0 && !cap_nod[n0] && cap_cmd[n0] == 8'h02,
        "R3 beat payload", {cap_cmd[n0], cap_dat[n0]}, 16'h023C);
  endtask

  task automatic t_two_byte_write;
    bit a; int n0 = cap_n;
    m_start;
    m_wbyte(CW, a); m_wbyte(8'h03, a);
    m_wbyte(8'hA1, a); chk(a, "R3 msb ack", a, 1);
    m_wbyte(8'hB2, a); chk(a, "R3 lsb ack", a, 1);
    m_stop;
    chk(cap_n == n0 + 2, "R3 two beats", cap_n - n0, 2);
    chk(cap_dat[n0] == 8'hA1 && cap_pos[n0] == 0, "R3 first beat", cap_dat[n0], 8'hA1);
    chk(cap_dat[n0+1] == 8'hB2 && cap_pos[n0+1] == 1, "R3 second beat", cap_dat[n0+1], 8'hB2);
  endtask

  task automatic t_standalone;
    bit a; int n0 = cap_n;
    m_start;
    m_wbyte(CW, a); m_wbyte(8'hD0, a);
    chk(a, "R4 standalone ack", a, 1);
    m_stop;
    chk(cap_n == n0 + 1 && cap_nod[n0] && cap_cmd[n0] == 8'hD0,
        "R4 nodata beat", cap_cmd[n0], 8'hD0);
  endtask

  task automatic t_bad_address;
    bit a;
    m_start; m_wbyte({4'b1011, 3'b011, 1'b0}, a);
    chk(!a, "R1 wrong select nack", a, 0);
    m_wbyte(8'h00, a);
    chk(!a, "R1 ignored after mismatch", a, 0);
    m_stop;
    m_start; m_wbyte(8'hAA, a);
    chk(!a, "R1 wrong code nack", a, 0);
    m_stop;
  endtask

  task automatic t_busy;
    bit a; int n0 = cap_n;
    m_start; m_wbyte(CW, a); m_wbyte(8'h02, a);
    busy = 1'b1;
    m_wbyte(8'h77, a); chk(!a, "R6 data nack while busy", a, 0);
    m_stop;
    m_start; m_wbyte(CW, a); chk(!a, "R6 ctrl nack while busy", a, 0);
    m_stop;
    chk(cap_n == n0, "R6 no beat while busy", cap_n - n0, 0);
    busy = 1'b0;
    m_start; m_wbyte(CW, a); chk(a, "R6 resume after busy", a, 1);
    m_stop;
  endtask

  task automatic t_backpressure;
    bit a; int n0 = cap_n;
    m_start; m_wbyte(CW, a); m_wbyte(8'h02, a);
    wr_ready = 1'b0;
    m_wbyte(8'h44, a); chk(!a, "R5 untaken beat nack", a, 0);
    m_stop;
    wr_ready = 1'b1;
    chk(cap_n == n0, "R5 no beat taken", cap_n - n0, 0);
  endtask

  task automatic t_read_two;
    bit a; logic [7:0] b;
    m_start; m_wbyte(CW, a); m_wbyte(8'h03, a); m_wbyte(8'h00, a); m_stop;
    m_start; m_wbyte(CR, a); chk(a, "R1 read ctrl ack", a, 1);
    m_rbyte(1'b1, b); chk(b == 8'hF3, "R7 read msb", b, 8'hF3);
    m_rbyte(1'b0, b); chk(b == 8'h0C, "R7 read lsb", b, 8'h0C);
    tick(Q);
    chk(!sda_pull, "R8 released after master nack", sda_pull, 0);
    m_stop;
  endtask

  task automatic t_read_one;
    bit a; logic [7:0] b;
    m_start; m_wbyte(CW, a); m_wbyte(8'h02, a); m_stop;
    m_start; m_wbyte(CR, a);
    m_rbyte(1'b0, b); chk(b == 8'h0D, "R7 one-byte read", b, 8'h0D);
    m_stop;
  endtask

  task automatic t_abort;
    bit a; int n0 = cap_n;
    m_start; m_bits(CW, 4);
    m_start;
    m_wbyte(CW, a); chk(a, "R9 ctrl ack after restart", a, 1);
    m_wbyte(8'h02, a); m_wbyte(8'h55, a);
    m_stop;
    chk(cap_n == n0 + 1 && cap_dat[n0] == 8'h55, "R9 write after abort", cap_dat[n0], 8'h55);
  endtask

  initial begin
    tick(5);
    t_reset;
    rst_n = 1'b1;
    tick(5);
    t_one_byte_write;
    t_two_byte_write;
    t_standalone;
    t_bad_address;
    t_busy;
    t_backpressure;
    t_read_two;
    t_read_one;
    t_abort;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule